// File: doc/BRIEF.md
# Cascadable Counter with Offset Bounds

This block is a synchronous up-counter built from a chain of narrow counting slices. Each slice advances only when the slice below it is full and the chain is enabled. A gated carry output lets further counters be chained outside the block. The counter has a synchronous clear, a synchronous parallel load and a count enable. Clear wins over load, and load wins over counting.

Two mode inputs bend the counting sequence. With the start offset on, the counter loads a programmed start value where it would otherwise roll over. With the end offset on, an equality compare against a programmed end value replaces the all-ones rollover point, and the counter returns to zero after that value. With both offsets on, the counter loads the start value after the end value. A user can therefore count over any window, such as 6 to 13, repeating.

Top module: `offset_span_counter`

## Requirements
- R1: While `rst_n` is low, or `clr_i` is high, at a rising edge, `count_o` becomes 0 at that edge, whatever `load_i` and `cnt_en_i` are.
- R2: When `clr_i` is low and `load_i` is high at a rising edge, `count_o` takes `load_val_i` at that edge, whatever `cnt_en_i` is and whether or not the count is at a wrap point.
- R3: When `clr_i`, `load_i` and `cnt_en_i` are all low at a rising edge, `count_o` keeps its value.
- R4: When only `cnt_en_i` is high and the count is not at its wrap point, `count_o` rises by exactly one. With both offsets off, the wrap point is all ones and the next value is 0.
- R5: `carry_o` is high exactly when `cnt_en_i` is high and every bit of `count_o` is 1. It is combinational from those signals.
- R6: A slice above the lowest slice advances only in a cycle in which every lower bit is 1 and counting is enabled. For example, with 4-bit slices, 0x0F steps to 0x10 and 0x0E steps to 0x0F.
- R7: With `start_mode_i`=1 and `end_mode_i`=0, an enabled step from all ones loads `start_val_i` in place of 0.
- R8: With `end_mode_i`=1 and `start_mode_i`=0, an enabled step taken while `count_o` equals `end_val_i` clears the count to 0. In this mode, all ones is no longer a wrap point.
- R9: With both mode inputs at 1, an enabled step taken while `count_o` equals `end_val_i` loads `start_val_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear, highest priority |
| load_i | input | 1 | Synchronous parallel load |
| cnt_en_i | input | 1 | Count enable |
| load_val_i | input | SLICE_W*SLICES | Value taken on load |
| start_mode_i | input | 1 | Restart from `start_val_i` at the wrap point |
| end_mode_i | input | 1 | Use `end_val_i` as the wrap point |
| start_val_i | input | SLICE_W*SLICES | Start of the counting window |
| end_val_i | input | SLICE_W*SLICES | End of the counting window |
| count_o | output | SLICE_W*SLICES | Current count |
| carry_o | output | 1 | Enabled all-ones carry for chaining |

## Verification
The bench uses the default build: two 4-bit slices, giving an 8-bit count. With two slices, the carry from the low slice into the high slice can be seen at the ports, as the step from 0x0F to 0x10. The full-width rollover at 0xFF is also reachable in a few cycles by loading close to it. End and start values are chosen to span both slices (0x1D and 0x36), so the equality compare and the restart load act on more than one slice.

// File: rtl/ospan_pkg.sv
// Shared types for the offset-bounded counter.
// Assumes nothing beyond the two mode inputs of the top module.
package ospan_pkg;

    // How the counter behaves at its wrap point
    typedef enum logic [1:0] {
        WRAP_FREE  = 2'b00,  // roll over from all ones to zero
        WRAP_START = 2'b01,  // all ones -> start value
        WRAP_END   = 2'b10,  // end value -> zero
        WRAP_BOTH  = 2'b11   // end value -> start value
    } wrap_mode_e;

endpackage

// File: rtl/count_slice.sv
// One counting slice: a synchronous counter with clear, load and enable.
// Bit i toggles only when every lower bit is 1. carry_o tells the next
// slice up to advance. Assumes clr_i and ld_i are already prioritised
// by the caller. This slice applies clear > load > enable itself.
module count_slice #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_d_i,
    input  logic         en_i,
    output logic [W-1:0] q_o,
    output logic         carry_o
);

    logic [W-1:0] q_r;
    logic [W-1:0] tgl;

    // Toggle mask: bit i flips when all bits below it are set
    always_comb begin
        tgl[0] = 1'b1;
        for (int i = 1; i < W; i++) begin
            tgl[i] = tgl[i-1] & q_r[i-1];
        end
    end

    // State register with clear, then load, then count
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            q_r <= '0;
        end else if (ld_i) begin
            q_r <= ld_d_i;
        end else if (en_i) begin
            q_r <= q_r ^ tgl;
        end
    end

    // Carry out to the next slice: enabled and full
    always_comb begin
        carry_o = en_i & tgl[W-1] & q_r[W-1];
    end

    assign q_o = q_r;

    // R6
    slice_carry_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> en_i);

    // R4
    slice_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !ld_i && !(&q_r)) |=> (q_r == W'($past(q_r) + 1'b1)));

endmodule

// File: rtl/wrap_ctrl.sv
// Wrap-point control for the offset counter. It decides whether the
// next enabled step is an ordinary increment, a clear to zero or a load
// of the start value. It turns that decision and the external clear and
// load into per-slice clear, load, load-data and enable. Assumes the
// count fed back is the registered output of the slice chain.
module wrap_ctrl
    import ospan_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic          cnt_en_i,
    input  logic          start_mode_i,
    input  logic          end_mode_i,
    input  logic [TW-1:0] count_i,
    input  logic [TW-1:0] load_val_i,
    input  logic [TW-1:0] start_val_i,
    input  logic [TW-1:0] end_val_i,
    output logic          s_clr_o,
    output logic          s_ld_o,
    output logic [TW-1:0] s_ld_d_o,
    output logic          s_en_o
);

    wrap_mode_e mode;
    logic       at_wrap;
    logic       wrap_step;

    // Mode from the two offset enables
    always_comb begin
        mode = wrap_mode_e'({end_mode_i, start_mode_i});
    end

    // Wrap point: end compare when end offset is on, else all ones
    always_comb begin
        case (mode)
            WRAP_END, WRAP_BOTH: at_wrap = (count_i == end_val_i);
            default:             at_wrap = &count_i;
        endcase
    end

    // A step taken at the wrap point with no external override
    always_comb begin
        wrap_step = cnt_en_i & at_wrap & ~load_i & ~clr_i;
    end

    // Per-slice controls: clear > external load > restart > count
    always_comb begin
        s_clr_o  = clr_i;
        s_ld_o   = load_i;
        s_ld_d_o = load_val_i;
        s_en_o   = cnt_en_i;
        if (wrap_step) begin
            case (mode)
                WRAP_START, WRAP_BOTH: begin
                    s_ld_o   = 1'b1;
                    s_ld_d_o = start_val_i;
                end
                WRAP_END: s_clr_o = 1'b1;
                default:  s_clr_o = 1'b0;
            endcase
        end
    end

    // R7
    start_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !clr_i && !load_i && start_mode_i && !end_mode_i && (&count_i))
        |=> (count_i == $past(start_val_i)));

    // R8
    end_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !clr_i && !load_i && !start_mode_i && end_mode_i && (count_i == end_val_i))
        |=> (count_i == '0));

    // R9
    both_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !clr_i && !load_i && start_mode_i && end_mode_i && (count_i == end_val_i))
        |=> (count_i == $past(start_val_i)));

endmodule

// File: rtl/offset_span_counter.sv
// Top of the offset-bounded cascadable counter. It chains SLICES
// counting slices of SLICE_W bits each. Each slice is enabled by the
// carry of the one below it. A wrap controller adds the start and end
// offsets. Assumes all inputs are synchronous to clk.
module offset_span_counter #(
    parameter int SLICE_W = 4,
    parameter int SLICES  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        load_i,
    input  logic                        cnt_en_i,
    input  logic [SLICE_W*SLICES-1:0]   load_val_i,
    input  logic                        start_mode_i,
    input  logic                        end_mode_i,
    input  logic [SLICE_W*SLICES-1:0]   start_val_i,
    input  logic [SLICE_W*SLICES-1:0]   end_val_i,
    output logic [SLICE_W*SLICES-1:0]   count_o,
    output logic                        carry_o
);

    localparam int TW = SLICE_W * SLICES;

    logic          s_clr;
    logic          s_ld;
    logic [TW-1:0] s_ld_d;
    logic          s_en;
    logic [SLICES:0] en_chain;

    wrap_ctrl #(.TW(TW)) u_wrap (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr_i),
        .load_i       (load_i),
        .cnt_en_i     (cnt_en_i),
        .start_mode_i (start_mode_i),
        .end_mode_i   (end_mode_i),
        .count_i      (count_o),
        .load_val_i   (load_val_i),
        .start_val_i  (start_val_i),
        .end_val_i    (end_val_i),
        .s_clr_o      (s_clr),
        .s_ld_o       (s_ld),
        .s_ld_d_o     (s_ld_d),
        .s_en_o       (s_en)
    );

    assign en_chain[0] = s_en;

    // Slice chain: each slice's carry enables the next one up
    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        count_slice #(.W(SLICE_W)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (s_clr),
            .ld_i    (s_ld),
            .ld_d_i  (s_ld_d[k*SLICE_W +: SLICE_W]),
            .en_i    (en_chain[k]),
            .q_o     (count_o[k*SLICE_W +: SLICE_W]),
            .carry_o (en_chain[k+1])
        );
    end

    assign carry_o = en_chain[SLICES];

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && load_i) |=> (count_o == $past(load_val_i)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !load_i && !cnt_en_i) |=> $stable(count_o));

    // R5
    carry_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o == (cnt_en_i && (&count_o)));

endmodule

// File: tb/offset_span_counter_tb.sv
// Directed bench for offset_span_counter. Inputs change on the falling
// edge and outputs are sampled on the falling edge after each rising edge.
module offset_span_counter_tb;

    localparam int SW = 4;
    localparam int NS = 2;
    localparam int TW = SW * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_i = 1'b0;
    logic          load_i = 1'b0;
    logic          cnt_en_i = 1'b0;
    logic [TW-1:0] load_val_i = '0;
    logic          start_mode_i = 1'b0;
    logic          end_mode_i = 1'b0;
    logic [TW-1:0] start_val_i = '0;
    logic [TW-1:0] end_val_i = '0;
    logic [TW-1:0] count_o;
    logic          carry_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    offset_span_counter #(.SLICE_W(SW), .SLICES(NS)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr_i),
        .load_i       (load_i),
        .cnt_en_i     (cnt_en_i),
        .load_val_i   (load_val_i),
        .start_mode_i (start_mode_i),
        .end_mode_i   (end_mode_i),
        .start_val_i  (start_val_i),
        .end_val_i    (end_val_i),
        .count_o      (count_o),
        .carry_o      (carry_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One rising edge, then land on the following falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_to(input logic [TW-1:0] v);
        load_i = 1'b1; load_val_i = v; cnt_en_i = 1'b0;
        tick();
        load_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cnt_en_i = 1'b1; load_i = 1'b1; load_val_i = 8'h55;
        tick(); tick();
        chk("R1 reset count", count_o, 0);
        cnt_en_i = 1'b0; load_i = 1'b0;
        rst_n = 1'b1;
        #1 chk("R5 reset carry", carry_o, 0);
    endtask

    task automatic t_cascade();
        load_to(8'h0D);
        chk("R2 load", count_o, 8'h0D);
        cnt_en_i = 1'b1;
        tick(); chk("R4 step", count_o, 8'h0E);
        tick(); chk("R6 low full", count_o, 8'h0F);
        #1 chk("R5 no carry at 0x0F", carry_o, 0);
        tick(); chk("R6 upper advance", count_o, 8'h10);
        cnt_en_i = 1'b0;
    endtask

    task automatic t_hold();
        load_to(8'h42);
        tick(); tick();
        chk("R3 hold", count_o, 8'h42);
    endtask

    task automatic t_free_wrap();
        load_to(8'hFE);
        cnt_en_i = 1'b1;
        tick(); chk("R4 to all ones", count_o, 8'hFF);
        #1 chk("R5 carry high", carry_o, 1);
        cnt_en_i = 1'b0;
        #1 chk("R5 carry gated by enable", carry_o, 0);
        cnt_en_i = 1'b1;
        tick(); chk("R4 rollover", count_o, 8'h00);
        #1 chk("R5 carry low after rollover", carry_o, 0);
        cnt_en_i = 1'b0;
    endtask

    task automatic t_start();
        start_mode_i = 1'b1; end_mode_i = 1'b0; start_val_i = 8'h36;
        load_to(8'hFE);
        cnt_en_i = 1'b1;
        tick(); chk("R7 reach all ones", count_o, 8'hFF);
        tick(); chk("R7 restart", count_o, 8'h36);
        tick(); chk("R7 continue", count_o, 8'h37);
        cnt_en_i = 1'b0; start_mode_i = 1'b0;
    endtask

    task automatic t_end();
        start_mode_i = 1'b0; end_mode_i = 1'b1; end_val_i = 8'h1D;
        load_to(8'h1C);
        cnt_en_i = 1'b1;
        tick(); chk("R8 reach end", count_o, 8'h1D);
        tick(); chk("R8 clear at end", count_o, 8'h00);
        cnt_en_i = 1'b0;
        load_to(8'hFF);
        cnt_en_i = 1'b1;
        tick(); chk("R8 all ones not a wrap", count_o, 8'h00);
        cnt_en_i = 1'b0; end_mode_i = 1'b0;
    endtask

    task automatic t_both();
        start_mode_i = 1'b1; end_mode_i = 1'b1;
        start_val_i = 8'h36; end_val_i = 8'h1D;
        load_to(8'h1C);
        cnt_en_i = 1'b1;
        tick(); chk("R9 reach end", count_o, 8'h1D);
        tick(); chk("R9 restart at end", count_o, 8'h36);
        cnt_en_i = 1'b0;
        // load wins over restart at the end point
        load_to(8'h1D);
        cnt_en_i = 1'b1; load_i = 1'b1; load_val_i = 8'h80;
        tick(); chk("R2 load beats wrap", count_o, 8'h80);
        load_i = 1'b0; cnt_en_i = 1'b0;
        start_mode_i = 1'b0; end_mode_i = 1'b0;
    endtask

    task automatic t_clear();
        load_to(8'h5A);
        clr_i = 1'b1; load_i = 1'b1; load_val_i = 8'h33; cnt_en_i = 1'b1;
        tick(); chk("R1 clear beats load", count_o, 0);
        clr_i = 1'b0; load_i = 1'b0; cnt_en_i = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_cascade();
        t_hold();
        t_free_wrap();
        t_start();
        t_end();
        t_both();
        t_clear();
        summary();
    end

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule